// File: doc/BRIEF.md
# Supply Voltage Supervisor Controller

This block is the digital control wrapped around an external low-voltage comparator. Software turns it on with an enable bit and a two-bit mode field. After turning on, the block waits through a settling interval counted on a slow tick strobe, then raises a ready flag. Only after ready does it let the comparator decide a detection flag, and only then can that flag raise an interrupt or a reset request.

The comparator input (high while the supply sits below its threshold, with hysteresis applied outside the block) passes through a synchronizer. In direct mode the flag follows the synchronized level. In sampled mode the settling interval is longer, the level is taken only on tick strobes, and the flag moves only when two consecutive samples agree. Mode bit 0 selects what is issued: a one-clock interrupt pulse or a level reset request.

Top module: `supply_monitor_ctrl`

## Requirements
- R1: The block is active only while `sv_enable` is 1 and `sv_mode[1]` is 1 (mode 2'b10 or 2'b11); otherwise `ready`, `detect`, `irq_pulse` and `reset_req` are 0.
- R2: With `sample_en` low, `ready` rises on the clock edge that counts the 4th `slow_tick` strobe seen while active, and stays high while active.
- R3: With `sample_en` high, `ready` rises on the edge that counts the 6th `slow_tick` strobe seen while active.
- R4: While `ready` is 0, `detect`, `irq_pulse` and `reset_req` are 0 whatever the comparator reports.
- R5: In direct mode, once ready, `detect` equals `cmp_low` delayed by two synchronizer flops plus the flag register (three clocks).
- R6: In sampled mode, `detect` changes only on a `slow_tick` edge, and only to a synchronized value that matched the sample taken on the previous tick.
- R7: In mode 2'b10, `irq_pulse` is high for exactly the first clock in which `detect` is high after being low; `reset_req` stays 0.
- R8: In mode 2'b11, `reset_req` equals `detect` and `irq_pulse` stays 0.
- R9: Leaving the active state clears `ready`, `detect` and the settling count on the next edge, so a later enable counts the full interval again.
- R10: After `rst_n` is released, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle strobe marking each slow clock period |
| sv_enable | input | 1 | Software enable bit |
| sv_mode | input | 2 | Mode: bit 1 selects supervisor operation, bit 0 selects reset (1) or interrupt (0) |
| sample_en | input | 1 | Selects sampled mode with longer settling and filtering |
| cmp_low | input | 1 | Comparator output, 1 while supply is below threshold |
| ready | output | 1 | Settling interval complete |
| detect | output | 1 | Masked low-voltage detection flag |
| irq_pulse | output | 1 | One-clock interrupt on detection onset |
| reset_req | output | 1 | Level reset request while detection persists |

## Verification
The assertions assume `sample_en` and `sv_mode[0]` are held steady while the block is active and that `slow_tick` never stays high for two clocks in a row. The bench changes mode, enable and sampling only between phases, with a disable in between, and generates the tick from a divider so strobes are always isolated. The comparator is toggled with hold times both shorter and longer than a tick period so that the sampled filter sees rejected glitches and accepted changes.

// File: rtl/supply_monitor_ctrl.sv
module supply_monitor_ctrl #(
  parameter int SETTLE_TICKS       = 4,
  parameter int SAMPLE_EXTRA_TICKS = 2,
  parameter int SYNC_STAGES        = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic       sv_enable,
  input  logic [1:0] sv_mode,
  input  logic       sample_en,
  input  logic       cmp_low,
  output logic       ready,
  output logic       detect,
  output logic       irq_pulse,
  output logic       reset_req
);
  localparam int LONG_TICKS = SETTLE_TICKS + SAMPLE_EXTRA_TICKS;
  localparam int CW = $clog2(LONG_TICKS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   ready_q, det_q, det_d1_q, smp_q;
  logic                   active, cmp_s;
  logic [CW-1:0]          last_cnt;

  assign active   = sv_enable & sv_mode[1];
  assign cmp_s    = sync_q[SYNC_STAGES-1];
  assign last_cnt = sample_en ? CW'(LONG_TICKS - 1) : CW'(SETTLE_TICKS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= '0;
      cnt_q    <= '0;
      ready_q  <= 1'b0;
      det_q    <= 1'b0;
      det_d1_q <= 1'b0;
      smp_q    <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], cmp_low};
      det_d1_q <= det_q;
      if (!active) begin
        cnt_q   <= '0;
        ready_q <= 1'b0;
        det_q   <= 1'b0;
        smp_q   <= 1'b0;
      end else begin
        if (slow_tick && !ready_q) begin
          if (cnt_q == last_cnt) ready_q <= 1'b1;
          else                   cnt_q   <= cnt_q + 1'b1;
        end
        if (!sample_en) begin
          det_q <= ready_q & cmp_s;
        end else if (slow_tick) begin
          smp_q <= cmp_s;
          if (!ready_q)            det_q <= 1'b0;
          else if (cmp_s == smp_q) det_q <= cmp_s;
        end else if (!ready_q) begin
          det_q <= 1'b0;
        end
      end
    end
  end

  assign ready     = ready_q;
  assign detect    = det_q;
  assign irq_pulse = ~sv_mode[0] & det_q & ~det_d1_q;
  assign reset_req = sv_mode[0] & det_q;

  // R4
  masked_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!detect && !irq_pulse && !reset_req));

  // R9
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!ready && !detect));

  // R7
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  // R2
  ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(slow_tick));

  // R6
  sampled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && sample_en && $past(sample_en) && !$past(slow_tick))
      |-> $stable(detect));

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < LONG_TICKS);
endmodule

// File: tb/test_supply_monitor_ctrl.sv
module test_supply_monitor_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0, sv_enable = 1'b0;
  logic [1:0] sv_mode = 2'b00;
  logic sample_en = 1'b0, cmp_low = 1'b0;
  logic ready, detect, irq_pulse, reset_req;

  int checks = 0, errors = 0, cycle = 0, div = 0;
  bit tick_on = 1'b0;

  bit m_s1, m_s2, m_ready, m_det, m_detq, m_smp;
  int m_cnt;

  supply_monitor_ctrl i_supply_monitor_ctrl (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .sv_enable(sv_enable),
    .sv_mode(sv_mode), .sample_en(sample_en), .cmp_low(cmp_low),
    .ready(ready), .detect(detect), .irq_pulse(irq_pulse), .reset_req(reset_req));

  always #4 clk = ~clk;

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %b expected %b", req, cycle, got, exp);
    end
  endtask

  // slow tick: one strobe every 5 clocks, driven on falling edges
  always @(negedge clk) begin
    div = (div == 4) ? 0 : div + 1;
    slow_tick <= tick_on && (div == 0);
  end

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    bit act, n_ready, n_det, n_smp;
    int n_cnt, last;
    cycle++;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_ready = 0; m_det = 0; m_detq = 0; m_smp = 0; m_cnt = 0;
    end else begin
      act = sv_enable && sv_mode[1];
      last = sample_en ? 5 : 3;
      n_ready = m_ready; n_det = m_det; n_smp = m_smp; n_cnt = m_cnt;
      if (!act) begin
        n_ready = 0; n_det = 0; n_smp = 0; n_cnt = 0;
      end else begin
        if (slow_tick && !m_ready) begin
          if (m_cnt == last) n_ready = 1; else n_cnt = m_cnt + 1;
        end
        if (!sample_en) n_det = m_ready && m_s2;
        else if (slow_tick) begin
          n_smp = m_s2;
          if (!m_ready) n_det = 0;
          else if (m_s2 == m_smp) n_det = m_s2;
        end else if (!m_ready) n_det = 0;
      end
      m_detq = m_det;
      m_s2 = m_s1; m_s1 = cmp_low;
      m_ready = n_ready; m_det = n_det; m_smp = n_smp; m_cnt = n_cnt;
    end
  end

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      check(ready, m_ready, sample_en ? "R3" : "R2");
      check(detect, m_det, sample_en ? "R6" : "R5");
      check(irq_pulse, !sv_mode[0] && m_det && !m_detq, "R7");
      check(reset_req, sv_mode[0] && m_det, "R8");
    end
  end

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wiggle(input int seed, input int steps);
    int s = seed;
    for (int i = 0; i < steps; i++) begin
      s = (s * 1103515245 + 12345) & 32'h7fffffff;
      cmp_low = ~cmp_low;
      wait_clk(1 + (s % 13));
    end
  endtask

  task automatic disable_and_check();
    sv_enable = 0;
    wait_clk(2);
    check(ready, 1'b0, "R9");
    check(detect, 1'b0, "R9");
    check(reset_req, 1'b0, "R9");
    cmp_low = 0;
    wait_clk(3);
  endtask

  initial begin
    wait_clk(3);
    check(ready, 1'b0, "R10");
    check(detect, 1'b0, "R10");
    check(irq_pulse, 1'b0, "R10");
    check(reset_req, 1'b0, "R10");
    rst_n = 1; tick_on = 1;
    wait_clk(2);
    check(ready, 1'b0, "R10");
    check(reset_req, 1'b0, "R10");

    // non-supervisor mode with enable: inactive
    sv_mode = 2'b01; sv_enable = 1; cmp_low = 1;
    wait_clk(40);
    check(ready, 1'b0, "R1");
    check(detect, 1'b0, "R1");
    check(reset_req, 1'b0, "R1");
    sv_enable = 0; cmp_low = 0;
    wait_clk(3);

    // interrupt mode, direct; comparator low-side asserted during settling
    sv_mode = 2'b10; sv_enable = 1; cmp_low = 1;
    wait_clk(8);
    check(ready, 1'b0, "R4");
    check(detect, 1'b0, "R4");
    check(irq_pulse, 1'b0, "R4");
    wait_clk(25);
    check(ready, 1'b1, "R2");
    check(detect, 1'b1, "R5");
    wiggle(7, 30);
    disable_and_check();

    // re-enable must count the whole interval again
    sv_enable = 1; cmp_low = 1;
    wait_clk(12);
    check(ready, 1'b0, "R9");
    wait_clk(20);
    wiggle(21, 20);
    disable_and_check();

    // reset mode, direct
    sv_mode = 2'b11; sv_enable = 1;
    wait_clk(30);
    cmp_low = 1;
    wait_clk(5);
    check(reset_req, 1'b1, "R8");
    check(irq_pulse, 1'b0, "R8");
    wiggle(99, 30);
    disable_and_check();

    // reset mode, sampled: short glitches and long holds
    sample_en = 1; sv_enable = 1;
    wait_clk(26);
    check(ready, 1'b0, "R3");
    wait_clk(10);
    check(ready, 1'b1, "R3");
    cmp_low = 1; wait_clk(2); cmp_low = 0;
    wait_clk(20);
    check(detect, 1'b0, "R6");
    cmp_low = 1;
    wait_clk(20);
    check(detect, 1'b1, "R6");
    wiggle(5, 30);
    disable_and_check();

    // interrupt mode, sampled
    sv_mode = 2'b10; sv_enable = 1;
    wait_clk(40);
    wiggle(77, 40);
    disable_and_check();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycle > 100000);
    checks++; errors++;
    $display("FAIL watchdog expired at cycle %0d: got running expected done", cycle);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule